// File: doc/BRIEF.md
# SDRAM Read-to-Write Turnaround Sequencer

This block sits on the controller side of an SDRAM data bus. It issues READ and WRITE commands for one requester and places each WRITE at the earliest clock that keeps the shared DQ bus free of contention. The burst length is four. The CAS latency is set to two or three by a configuration input.

A read request is accepted whenever no write is pending. A read burst may be cut short by a later read. When a write request arrives, the block stops taking reads and raises the data mask. It holds the requester off until three conditions are met:
- the mask lead has been given;
- every read word that could still reach the bus near the write has been suppressed;
- one idle bus cycle separates the last word the memory actually drives from the WRITE command.

The controller then drives write data for four clocks, starting on the WRITE command cycle.

Top module: `sdr_turnaround_seq`

## Requirements
- R1: `cmd` is 2'b01 (READ) on a clock where `rd_valid` and `rd_ready` are both high, 2'b10 (WRITE) on a clock where `wr_valid` and `wr_ready` are both high, and 2'b00 (NOP) on every other clock; the two handshakes never complete on the same clock.
- R2: Directly after reset: `cmd` is NOP, `dqm` is low, `dq_oe` is low, `wr_ready` is low and `rd_ready` is high.
- R3: `rd_ready` is low from the clock after `wr_valid` is first seen high while idle, through the last clock of the write data burst.
- R4: `dqm` is high on the two clocks before a WRITE command and low on the WRITE command clock.
- R5: Let r be the clock on which `wr_valid` is first seen high while idle, and let p = r+1. Let t be the clock of the last READ, and let L be the CAS latency (L=3 when `cas_lat3` is 1, otherwise L=2). The WRITE is issued at w0 = max(p+2, t+L+2). If w0 <= t+L+4 and w0 < p+3, the WRITE is issued at p+3 instead. With no recent READ, the WRITE is issued at p+2.
- R6: A read word is driven by the memory at clock k when k-t-L lies in 0..3 and `dqm` was low at clock k-2. No such clock coincides with `dq_oe` high.
- R7: On the clock before a WRITE command, the memory drives no read word.
- R8: `dq_oe` is high on exactly the WRITE clock and the three clocks after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cas_lat3 | input | 1 | CAS latency select: 1 = three clocks, 0 = two clocks |
| rd_valid | input | 1 | Read request |
| rd_ready | output | 1 | Read request accepted when high together with rd_valid |
| wr_valid | input | 1 | Write request, held until accepted |
| wr_ready | output | 1 | Write slot reached; accepted when high together with wr_valid |
| cmd | output | 2 | Command this clock: 00 NOP, 01 READ, 10 WRITE |
| dqm | output | 1 | Data mask toward the memory |
| dq_oe | output | 1 | Controller drive enable for DQ |

## Verification
`cmd` and both ready lines respond in the same clock as the handshake inputs, so the bench drives inputs just after a rising edge and samples just after them, within that clock. The WRITE clock follows the R5 formula, counted from the clock on which the request was first presented. A bus model checks `dq_oe` and the memory's drive in the WRITE clock and in each of the three clocks after it. That model applies the two-clock mask delay to the `dqm` it observed, so a read word at clock k is judged against the mask two samples earlier. The sweep covers both latencies and every request offset from 0 to 8 clocks after a READ, plus the case with no read.

// File: rtl/sdr_ta_pkg.sv
package sdr_ta_pkg;
    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10
    } sdr_cmd_e;

    typedef enum logic [1:0] {
        M_IDLE   = 2'b00,
        M_PREP   = 2'b01,
        M_WBURST = 2'b10
    } ta_mode_e;

    localparam int CL_SHORT = 2;
    localparam int CL_LONG  = 3;
endpackage

// File: rtl/sdr_ta_rd_tracker.sv
module sdr_ta_rd_tracker #(
    parameter int CNT_W = 4,
    parameter int SAT   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_fire,
    output logic [CNT_W-1:0] since_rd
);
    localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);

    logic [CNT_W-1:0] since_d, since_q;

    always_comb begin
        since_d = since_q;
        if (rd_fire)
            since_d = CNT_W'(1);
        else if (since_q < SAT_V)
            since_d = since_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) since_q <= SAT_V;
        else        since_q <= since_d;
    end

    assign since_rd = since_q;

    AST_RD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> since_q == CNT_W'(1)); // R5
endmodule

// File: rtl/sdr_ta_slot_calc.sv
module sdr_ta_slot_calc #(
    parameter int CNT_W    = 4,
    parameter int PREP_W   = 2,
    parameter int BURST    = 4,
    parameter int DQM_LEAD = 2
) (
    input  logic              cas_lat3,
    input  logic [CNT_W-1:0]  since_rd,
    input  logic [PREP_W-1:0] prep_cnt,
    output logic              slot_ok
);
    import sdr_ta_pkg::*;

    int  cl;
    int  s;
    int  pc;
    logic tail_clear;
    logic word_before;

    always_comb begin
        cl = cas_lat3 ? CL_LONG : CL_SHORT;
        s  = int'(since_rd);
        pc = int'(prep_cnt);
        // all words after the lead window must already be past
        tail_clear  = (s >= cl + BURST - DQM_LEAD);
        // a word would land on the gap clock and needs one more mask clock
        word_before = (s <= cl + BURST);
        slot_ok = tail_clear && (pc >= DQM_LEAD) &&
                  (!word_before || (pc >= DQM_LEAD + 1));
    end
endmodule

// File: rtl/sdr_turnaround_seq.sv
module sdr_turnaround_seq #(
    parameter int BURST    = 4,
    parameter int DQM_LEAD = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cas_lat3,
    input  logic       rd_valid,
    output logic       rd_ready,
    input  logic       wr_valid,
    output logic       wr_ready,
    output logic [1:0] cmd,
    output logic       dqm,
    output logic       dq_oe
);
    import sdr_ta_pkg::*;

    localparam int SAT     = CL_LONG + BURST + 1;
    localparam int CNT_W   = $clog2(SAT + 1);
    localparam int PREP_W  = $clog2(DQM_LEAD + 2);
    localparam int BCNT_W  = $clog2(BURST);
    localparam logic [PREP_W-1:0] PREP_MAX = PREP_W'(DQM_LEAD + 1);

    typedef struct packed {
        ta_mode_e          mode;
        logic [PREP_W-1:0] prep;
        logic [BCNT_W-1:0] bleft;
    } st_t;

    st_t st_d, st_q;

    logic [CNT_W-1:0] since_rd;
    logic             slot_ok;
    logic             rd_fire;
    logic             wr_fire;

    sdr_ta_rd_tracker #(.CNT_W(CNT_W), .SAT(SAT)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_fire  (rd_fire),
        .since_rd (since_rd)
    );

    sdr_ta_slot_calc #(
        .CNT_W(CNT_W), .PREP_W(PREP_W), .BURST(BURST), .DQM_LEAD(DQM_LEAD)
    ) u_slot (
        .cas_lat3 (cas_lat3),
        .since_rd (since_rd),
        .prep_cnt (st_q.prep),
        .slot_ok  (slot_ok)
    );

    assign rd_ready = (st_q.mode == M_IDLE);
    assign wr_ready = (st_q.mode == M_PREP) && slot_ok;
    assign rd_fire  = rd_valid && rd_ready;
    assign wr_fire  = wr_valid && wr_ready;
    assign dqm      = (st_q.mode == M_PREP) && !slot_ok;
    assign dq_oe    = wr_fire || (st_q.mode == M_WBURST);

    always_comb begin
        if (wr_fire)      cmd = CMD_WRITE;
        else if (rd_fire) cmd = CMD_READ;
        else              cmd = CMD_NOP;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            M_IDLE: begin
                if (wr_valid) begin
                    st_d.mode = M_PREP;
                    st_d.prep = '0;
                end
            end
            M_PREP: begin
                if (!wr_valid) begin
                    st_d.mode = M_IDLE;
                    st_d.prep = '0;
                end else if (slot_ok) begin
                    st_d.mode  = M_WBURST;
                    st_d.bleft = BCNT_W'(BURST - 2);
                    st_d.prep  = '0;
                end else if (st_q.prep < PREP_MAX) begin
                    st_d.prep = st_q.prep + PREP_W'(1);
                end
            end
            M_WBURST: begin
                if (st_q.bleft == '0) st_d.mode = M_IDLE;
                else                  st_d.bleft = st_q.bleft - BCNT_W'(1);
            end
            default: st_d.mode = M_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode  <= M_IDLE;
            st_q.prep  <= '0;
            st_q.bleft <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_ONE_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_fire && wr_fire)); // R1
    AST_DQM_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WRITE) |-> ($past(dqm) && $past(dqm, 2))); // R4
    AST_DQM_OFF_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WRITE) |-> !dqm); // R4
    AST_NO_READ_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (cmd != CMD_READ)); // R3
    AST_OE_STARTS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> (cmd == CMD_WRITE)); // R8
    AST_OE_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && cmd != CMD_WRITE) |-> $past(dq_oe)); // R8
endmodule

// File: tb/sdr_turnaround_seq_bench.sv
module sdr_turnaround_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cas_lat3 = 1'b0;
    logic       rd_valid = 1'b0;
    logic       wr_valid = 1'b0;
    logic       rd_ready;
    logic       wr_ready;
    logic [1:0] cmd;
    logic       dqm;
    logic       dq_oe;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    // bus model state
    bit rd_seen = 0;
    int rd_t = 0;
    int rd_cl = 2;
    bit wr_seen = 0;
    int wr_t = 0;
    bit dqm_h1 = 0;
    bit dqm_h2 = 0;
    bit mem_prev = 0;

    always #2.5 clk = ~clk;

    sdr_turnaround_seq u_sdr_turnaround_seq (
        .clk(clk), .rst_n(rst_n), .cas_lat3(cas_lat3),
        .rd_valid(rd_valid), .rd_ready(rd_ready),
        .wr_valid(wr_valid), .wr_ready(wr_ready),
        .cmd(cmd), .dqm(dqm), .dq_oe(dq_oe)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // bus owner monitor, mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            bit mem_now;
            bit oe_exp;
            int idx;
            if (cmd == 2'b01) begin
                rd_seen = 1; rd_t = cyc; rd_cl = cas_lat3 ? 3 : 2;
            end
            if (cmd == 2'b10) begin
                wr_seen = 1; wr_t = cyc;
                check(dqm_h1 && dqm_h2, "R4 lead", {dqm_h2, dqm_h1}, 3);
                check(!dqm, "R4 off", dqm, 0);
                check(!mem_prev, "R7 gap", mem_prev, 0);
            end
            idx = cyc - rd_t - rd_cl;
            mem_now = rd_seen && idx >= 0 && idx <= 3 && !dqm_h2;
            check(!(mem_now && dq_oe), "R6 contention", dq_oe, 0);
            oe_exp = wr_seen && (cyc - wr_t) >= 0 && (cyc - wr_t) <= 3;
            check(dq_oe == oe_exp, "R8 oe", dq_oe, oe_exp);
            mem_prev = mem_now;
            dqm_h2 = dqm_h1;
            dqm_h1 = dqm;
        end
    end

    task automatic run_trial(input bit cl3, input bit with_rd, input int d);
        int cl;
        int t;
        int r;
        int w;
        int p;
        int w_exp;
        bit got;
        cl = cl3 ? 3 : 2;
        cas_lat3 = cl3;
        repeat (12) @(posedge clk);
        t = -100; r = -100; w = -1; got = 0;
        for (int i = 0; i < 40 && !got; i++) begin
            @(posedge clk); #1;
            rd_valid = with_rd && (i == 0);
            if (i == d) begin wr_valid = 1'b1; r = cyc; end
            #0.5;
            if (rd_valid && i == 0) begin
                t = cyc;
                check(cmd == 2'b01, "R1 read cmd", cmd, 1);
            end
            if (i > d)
                check(!rd_ready, "R3 reads held", rd_ready, 0);
            if (wr_valid && wr_ready) begin
                got = 1; w = cyc;
                check(cmd == 2'b10, "R1 write cmd", cmd, 2);
            end else if (!rd_valid) begin
                check(cmd == 2'b00, "R1 nop", cmd, 0);
            end
        end
        @(posedge clk); #1;
        rd_valid = 1'b0; wr_valid = 1'b0;
        p = r + 1;
        if (!with_rd) w_exp = p + 2;
        else begin
            w_exp = (p + 2 > t + cl + 2) ? p + 2 : t + cl + 2;
            if (w_exp <= t + cl + 4 && w_exp < p + 3) w_exp = p + 3;
        end
        check(got && w == w_exp, "R5 slot", w - r, w_exp - r);
        repeat (3) begin
            #0.5;
            check(!rd_ready, "R3 burst", rd_ready, 0);
            @(posedge clk); #1;
        end
        #0.5;
        check(rd_ready, "R3 release", rd_ready, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        check(cmd == 2'b00, "R2 cmd", cmd, 0);
        check(!dqm && !dq_oe, "R2 dqm/oe", {dqm, dq_oe}, 0);
        check(!wr_ready && rd_ready, "R2 ready", {rd_ready, wr_ready}, 2);
        for (int c = 0; c < 2; c++) begin
            run_trial(c[0], 1'b0, 0);
            for (int d = 0; d <= 8; d++) run_trial(c[0], 1'b1, d);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule